// File: doc/BRIEF.md
# Operand Forwarding and Interlock Unit

This unit sits beside the decode stage of a four-stage pipeline (fetch, decode, execute, write-back). It sees the two source register numbers of the instruction now in decode, which moves into execute next, and the destination number, write enable and result of the instructions now in execute and write-back. Operands are read during decode but used only in execute. The unit therefore picks, for each operand, the value that the instruction will carry into execute. That value is the register-file read, the execute-stage ALU output produced at the end of this cycle, or the value that write-back is committing this cycle. When both stages hold a matching write, the younger one (execute) wins. Register 0 may be treated as a constant zero that is never forwarded.

A mode input turns forwarding off. The unit then returns plain register-file operands and interlocks instead. It raises `stall`, which holds decode and sends a bubble into execute, while any source matches a pending write. A pending write is one in execute, in write-back, or the one that left write-back in the previous cycle, because a register-file write only becomes readable one cycle after it commits. A dependent instruction that directly follows its producer therefore waits three cycles.

Top module: `operand_bypass_unit`

## Requirements
- R1: After reset, with no stage valid and forwarding off, `stall` is 0 and both selects are 00. No write seen before reset causes an interlock.
- R2: With `fwd_en`=1, a decode source that equals a valid, writing execute-stage destination gets select 01, and its operand output equals `ie_result`.
- R3: With `fwd_en`=1, a decode source that equals a valid, writing write-back destination, and no execute match, gets select 10, and its operand output equals `rw_result`.
- R4: When both execute and write-back match a source, select 01 (execute) is chosen.
- R5: A stage is a source of forwarding or interlock only when its valid and its write enable are both 1.
- R6: With ZERO_REG=1, source register 0 never matches. Its select is 00 and its operand is the register-file value.
- R7: The two operands are resolved independently. Each may pick a different source in the same cycle.
- R8: With `fwd_en`=1, `stall` is never asserted.
- R9: With `fwd_en`=0, both selects are 00 and the operands are the register-file values. `stall` is 1 while a valid decode source matches a live write in execute, in write-back, or the live write that was in write-back one cycle earlier.
- R10: With `fwd_en`=0, a dependent instruction that directly follows its producer sees `stall` for exactly three cycles.
- R11: With `id_valid`=0, `stall` is 0 and both selects are 00.

Select encoding: 00 register file, 01 execute result, 10 write-back result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fwd_en | input | 1 | 1 = forward, 0 = interlock |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | $clog2(NREG) | First source register |
| id_rs2 | input | $clog2(NREG) | Second source register |
| rf_rd1 | input | XLEN | Register-file value for first source |
| rf_rd2 | input | XLEN | Register-file value for second source |
| ie_valid | input | 1 | Execute stage holds an instruction |
| ie_we | input | 1 | Execute instruction writes a register |
| ie_rd | input | $clog2(NREG) | Execute destination |
| ie_result | input | XLEN | ALU output of execute stage |
| rw_valid | input | 1 | Write-back stage holds an instruction |
| rw_we | input | 1 | Write-back instruction writes a register |
| rw_rd | input | $clog2(NREG) | Write-back destination |
| rw_result | input | XLEN | Value being written back |
| stall | output | 1 | Hold decode, insert bubble |
| sel1 | output | 2 | Source select, first operand |
| sel2 | output | 2 | Source select, second operand |
| opnd1 | output | XLEN | Resolved first operand |
| opnd2 | output | XLEN | Resolved second operand |

## Verification
The bench builds the unit with NREG=8 and XLEN=16. With only eight registers, random streams produce frequent collisions, double matches and hits on register 0, so the priority and zero-register paths are exercised often. The narrow data width still leaves each forwarded value distinct enough to show which source reached each operand.

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit #(
  parameter int NREG     = 32,
  parameter int XLEN     = 32,
  parameter int ZERO_REG = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fwd_en,
  input  logic                    id_valid,
  input  logic [$clog2(NREG)-1:0] id_rs1,
  input  logic [$clog2(NREG)-1:0] id_rs2,
  input  logic [XLEN-1:0]         rf_rd1,
  input  logic [XLEN-1:0]         rf_rd2,
  input  logic                    ie_valid,
  input  logic                    ie_we,
  input  logic [$clog2(NREG)-1:0] ie_rd,
  input  logic [XLEN-1:0]         ie_result,
  input  logic                    rw_valid,
  input  logic                    rw_we,
  input  logic [$clog2(NREG)-1:0] rw_rd,
  input  logic [XLEN-1:0]         rw_result,
  output logic                    stall,
  output logic [1:0]              sel1,
  output logic [1:0]              sel2,
  output logic [XLEN-1:0]         opnd1,
  output logic [XLEN-1:0]         opnd2
);
  localparam int RB = $clog2(NREG);
  localparam logic [1:0] SEL_RF = 2'b00, SEL_IE = 2'b01, SEL_RW = 2'b10;

  logic          ie_live, rw_live;
  logic          ret_live_q;
  logic [RB-1:0] ret_rd_q;

  assign ie_live = ie_valid & ie_we;
  assign rw_live = rw_valid & rw_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ret_live_q <= 1'b0;
      ret_rd_q   <= '0;
    end else begin
      ret_live_q <= rw_live;
      ret_rd_q   <= rw_rd;
    end

  logic [RB-1:0]   src  [2];
  logic [XLEN-1:0] rf   [2];
  logic [1:0]      sel  [2];
  logic [XLEN-1:0] opnd [2];
  logic [1:0]      need;

  assign src[0] = id_rs1;
  assign src[1] = id_rs2;
  assign rf[0]  = rf_rd1;
  assign rf[1]  = rf_rd2;

  for (genvar i = 0; i < 2; i++) begin : g_op
    logic nz, hit_ie, hit_rw, hit_ret;
    assign nz      = (ZERO_REG == 0) || (src[i] != '0);
    assign hit_ie  = id_valid && nz && ie_live    && (ie_rd    == src[i]);
    assign hit_rw  = id_valid && nz && rw_live    && (rw_rd    == src[i]);
    assign hit_ret = id_valid && nz && ret_live_q && (ret_rd_q == src[i]);
    assign need[i] = hit_ie | hit_rw | hit_ret;
    assign sel[i]  = !fwd_en ? SEL_RF :
                     hit_ie  ? SEL_IE :
                     hit_rw  ? SEL_RW : SEL_RF;
    always_comb
      case (sel[i])
        SEL_IE:  opnd[i] = ie_result;
        SEL_RW:  opnd[i] = rw_result;
        default: opnd[i] = rf[i];
      endcase
  end

  assign stall = !fwd_en && (|need);
  assign sel1  = sel[0];
  assign sel2  = sel[1];
  assign opnd1 = opnd[0];
  assign opnd2 = opnd[1];
endmodule

module operand_bypass_unit_chk #(
  parameter int NREG     = 32,
  parameter int XLEN     = 32,
  parameter int ZERO_REG = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fwd_en,
  input logic                    id_valid,
  input logic [$clog2(NREG)-1:0] id_rs1,
  input logic [$clog2(NREG)-1:0] id_rs2,
  input logic [XLEN-1:0]         rf_rd1,
  input logic                    ie_valid,
  input logic                    ie_we,
  input logic [$clog2(NREG)-1:0] ie_rd,
  input logic [XLEN-1:0]         ie_result,
  input logic                    rw_valid,
  input logic                    rw_we,
  input logic [$clog2(NREG)-1:0] rw_rd,
  input logic [XLEN-1:0]         rw_result,
  input logic                    stall,
  input logic [1:0]              sel1,
  input logic [1:0]              sel2,
  input logic [XLEN-1:0]         opnd1
);
  assert_ie_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel1 == 2'b01 |-> opnd1 == ie_result);
  assert_rw_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel1 == 2'b10 |-> opnd1 == rw_result);
  assert_ie_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en && id_valid && id_rs1 != '0 && ie_valid && ie_we && ie_rd == id_rs1
    && rw_valid && rw_we && rw_rd == id_rs1 |-> sel1 == 2'b01);
  assert_dead_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ie_valid && ie_we) && !(rw_valid && rw_we) |-> sel1 == 2'b00 && sel2 == 2'b00);
  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ZERO_REG != 0 && id_rs1 == '0 |-> sel1 == 2'b00 && opnd1 == rf_rd1);
  assert_no_stall_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en |-> !stall);
  assert_rf_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> sel1 == 2'b00 && sel2 == 2'b00 && opnd1 == rf_rd1);
  assert_retired_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en && id_valid && id_rs1 != '0 && $past(rw_valid && rw_we)
    && $past(rw_rd) == id_rs1 |-> stall);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !stall && sel1 == 2'b00 && sel2 == 2'b00);
endmodule

bind operand_bypass_unit operand_bypass_unit_chk #(
  .NREG(NREG), .XLEN(XLEN), .ZERO_REG(ZERO_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .id_valid(id_valid),
  .id_rs1(id_rs1), .id_rs2(id_rs2), .rf_rd1(rf_rd1),
  .ie_valid(ie_valid), .ie_we(ie_we), .ie_rd(ie_rd), .ie_result(ie_result),
  .rw_valid(rw_valid), .rw_we(rw_we), .rw_rd(rw_rd), .rw_result(rw_result),
  .stall(stall), .sel1(sel1), .sel2(sel2), .opnd1(opnd1)
);

// File: tb/tb_operand_bypass_unit.sv
`timescale 1ns/1ps
module tb_operand_bypass_unit;
  localparam int NREG = 8, XLEN = 16, RB = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic fwd_en, id_valid, ie_valid, ie_we, rw_valid, rw_we, stall;
  logic [RB-1:0] id_rs1, id_rs2, ie_rd, rw_rd;
  logic [XLEN-1:0] rf_rd1, rf_rd2, ie_result, rw_result, opnd1, opnd2;
  logic [1:0] sel1, sel2;

  operand_bypass_unit #(.NREG(NREG), .XLEN(XLEN), .ZERO_REG(1)) dut (.*);

  typedef struct { bit v; bit we; int rd; int rs1; int rs2; } ins_t;
  ins_t bub = '{0, 0, 0, 0, 0};
  ins_t s_id, s_ie, s_rw, s_ret;
  ins_t q[$];
  int total = 0, bad = 0, stall_cnt = 0;

  function automatic bit hits(int src, ins_t s);
    return s.v && s.we && s.rd == src && src != 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag);
    int e1, e2, x1, x2;
    bit est;
    @(negedge clk);
    id_valid = s_id.v; id_rs1 = RB'(s_id.rs1); id_rs2 = RB'(s_id.rs2);
    ie_valid = s_ie.v; ie_we = s_ie.we; ie_rd = RB'(s_ie.rd);
    rw_valid = s_rw.v; rw_we = s_rw.we; rw_rd = RB'(s_rw.rd);
    rf_rd1 = XLEN'($urandom); rf_rd2 = XLEN'($urandom);
    ie_result = XLEN'($urandom); rw_result = XLEN'($urandom);
    #1;
    e1 = 0; e2 = 0;
    if (fwd_en && s_id.v) begin
      if (hits(s_id.rs1, s_ie)) e1 = 1; else if (hits(s_id.rs1, s_rw)) e1 = 2;
      if (hits(s_id.rs2, s_ie)) e2 = 1; else if (hits(s_id.rs2, s_rw)) e2 = 2;
    end
    x1 = (e1 == 1) ? int'(ie_result) : (e1 == 2) ? int'(rw_result) : int'(rf_rd1);
    x2 = (e2 == 1) ? int'(ie_result) : (e2 == 2) ? int'(rw_result) : int'(rf_rd2);
    est = !fwd_en && s_id.v &&
          (hits(s_id.rs1, s_ie) || hits(s_id.rs1, s_rw) || hits(s_id.rs1, s_ret) ||
           hits(s_id.rs2, s_ie) || hits(s_id.rs2, s_rw) || hits(s_id.rs2, s_ret));
    chk(tag, "stall", int'(stall), int'(est));
    chk(tag, "sel1", int'(sel1), e1);
    chk(tag, "sel2", int'(sel2), e2);
    chk(tag, "opnd1", int'(opnd1), x1);
    chk(tag, "opnd2", int'(opnd2), x2);
    if (stall) stall_cnt++;
    s_ret = s_rw; s_rw = s_ie;
    if (est) s_ie = bub;
    else begin
      s_ie = s_id;
      s_id = (q.size() > 0) ? q.pop_front() : bub;
    end
  endtask

  task automatic issue(bit v, bit we, int rd, int rs1, int rs2);
    q.push_back('{v, we, rd, rs1, rs2});
  endtask

  task automatic drain(string tag);
    while (q.size() > 0) cycle(tag);
    repeat (5) cycle(tag);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    s_id = bub; s_ie = bub; s_rw = bub; s_ret = bub;
    fwd_en = 0; id_valid = 0; id_rs1 = 0; id_rs2 = 0;
    ie_valid = 0; ie_we = 0; ie_rd = 0; rw_valid = 0; rw_we = 0; rw_rd = 0;
    rf_rd1 = 0; rf_rd2 = 0; ie_result = 0; rw_result = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    cycle("R1"); cycle("R1");

    fwd_en = 1;
    issue(1, 1, 3, 1, 2); issue(1, 0, 0, 3, 5); drain("R2");
    issue(1, 1, 4, 1, 1); issue(1, 0, 0, 1, 1); issue(1, 0, 0, 6, 4); drain("R3");
    issue(1, 1, 6, 0, 0); issue(1, 1, 6, 0, 0); issue(1, 0, 0, 6, 6); drain("R4");
    issue(1, 0, 2, 1, 1); issue(0, 1, 2, 0, 0); issue(1, 0, 0, 2, 2); drain("R5");
    issue(1, 1, 0, 1, 1); issue(1, 1, 0, 0, 0); drain("R6");
    issue(1, 1, 5, 0, 0); issue(1, 1, 7, 0, 0); issue(1, 0, 0, 5, 7); drain("R7");
    for (int i = 0; i < 300; i++)
      issue($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7),
            $urandom_range(0, 7), $urandom_range(0, 7));
    drain("R8");

    fwd_en = 0;
    issue(1, 1, 4, 0, 0); issue(1, 0, 0, 1, 1); issue(1, 0, 0, 2, 4); drain("R9");
    issue(1, 1, 0, 0, 0); issue(1, 0, 0, 0, 0); drain("R6");
    issue(1, 0, 1, 0, 0); issue(0, 1, 1, 0, 0); issue(1, 0, 0, 1, 1); drain("R5");
    stall_cnt = 0;
    issue(1, 1, 3, 0, 0); issue(1, 0, 0, 3, 0); drain("R10");
    chk("R10", "stall cycles", stall_cnt, 3);
    issue(1, 1, 6, 0, 0); issue(0, 0, 0, 6, 6); issue(0, 0, 0, 6, 6); drain("R11");

    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) fwd_en = $urandom_range(0, 1);
      issue($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7),
            $urandom_range(0, 7), $urandom_range(0, 7));
      cycle(fwd_en ? "R7" : "R9");
    end
    drain("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule